// File: doc/BRIEF.md
# Pulse-Counted Glitch Command Scheduler

This block times two voltage-regulator requests against activity on a watched SPI bus. After it is armed, it watches the asynchronous active-low chip-select line and counts high-to-low transitions until a programmed number has been seen. It then starts a tick counter that advances once per clock cycle. The counter raises a "drop" trigger, which asks the command transmitter for the low setpoint. It later raises a "restore" trigger, which asks for the voltage in use before the drop. The restore trigger comes exactly `delay` ticks after the last counted pulse, and the drop trigger comes `duration` ticks before it. Because the restore request normally goes out before the regulator can settle at the low setpoint, a single duration value shapes the dip. A fault-time marker follows the restore trigger by one cycle.

The controller is a five-state machine. ST_IDLE waits for arm. ST_COUNT counts chip-select falls. ST_WAIT runs the tick counter and issues both triggers. ST_DONE holds after a completed attempt. ST_ERR holds after a rejected configuration. The transitions are:
- arm accepted from ST_IDLE, ST_DONE or ST_ERR goes to ST_COUNT, or to ST_WAIT when the pulse target is zero, or to ST_ERR when duration exceeds delay.
- the last counted fall moves ST_COUNT to ST_WAIT.
- the restore tick moves ST_WAIT to ST_DONE.

An arm in ST_COUNT or ST_WAIT is ignored.

A pulse target of zero starts the tick counter directly from the arm. Software uses this to place the drop request before the first bus pulse when the dip is longer than the time available.

Top module: `glitch_sched`

## Requirements
- R1: After reset, drop_fire, restore_fire, fault_mark and param_err are all 0, and chip-select activity produces no trigger until arm is sampled high.
- R2: Chip-select passes through a two-stage synchronizer. Only high-to-low transitions are counted, so a line held low for many cycles counts once.
- R3: If the last counted fall of cs_n is set up before rising edge n, then restore_fire is a single-cycle pulse in the cycle after edge n+2+delay.
- R4: drop_fire is a single-cycle pulse in the cycle after edge n+2+delay-duration. When duration is 0, it coincides with restore_fire.
- R5: fault_mark is a single-cycle pulse in the cycle immediately after restore_fire.
- R6: When the pulse target is 0, the arm accepted at edge a starts the ticks. restore_fire follows edge a+delay and drop_fire follows edge a+delay-duration.
- R7: If duration > delay when arm is accepted, param_err goes to 1 after that edge and no trigger fires. The next accepted arm with duration <= delay clears param_err.
- R8: Pulse target, delay and duration are captured at the accepted arm. An arm while counting or ticking is ignored and does not change the timing.
- R9: One attempt per arm. After restore_fire, neither trigger fires again until re-armed. Chip-select falls during ticking do not affect the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Monitored SPI chip-select, asynchronous, active low |
| arm | input | 1 | Start an attempt and capture the parameters |
| pulse_target | input | CNT_W | Number of chip-select falls to count |
| delay_ticks | input | TICK_W | Ticks from last counted fall to restore trigger |
| dur_ticks | input | TICK_W | Ticks between drop and restore triggers |
| drop_fire | output | 1 | Low-setpoint command trigger |
| restore_fire | output | 1 | Previous-setpoint command trigger |
| fault_mark | output | 1 | Marks the fault instant, one cycle after restore |
| param_err | output | 1 | Configuration rejected (duration > delay) |

## Verification
The hardest situation to reach from the ports is a second arm that arrives while an attempt is already counting or ticking, together with extra bus pulses in the tick window. Both must leave the original timing untouched. Directed sequences inject a conflicting arm between counted pulses and send surplus pulses after the last counted one. The expected trigger cycles are derived from the first configuration alone. Randomized attempts vary the pulse widths, gaps, targets, delays and durations, including zero delay and zero duration, and compare the observed trigger cycles with the edge arithmetic of R3 to R5.

// File: rtl/glitch_sched_pkg.sv
package glitch_sched_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_WAIT,
        ST_DONE,
        ST_ERR
    } sched_state_t;
endpackage

// File: rtl/cs_fall_detect.sv
module cs_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_async,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b1;
                end else if (g == 0) begin
                    sync_q[g] <= cs_n_async;
                end else begin
                    sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign fall = prev_q & ~sync_q[STAGES-1];

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);  // R2
endmodule

// File: rtl/sched_counter.sv
module sched_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end
endmodule

// File: rtl/glitch_sched.sv
module glitch_sched
    import glitch_sched_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int TICK_W    = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              arm,
    input  logic [CNT_W-1:0]  pulse_target,
    input  logic [TICK_W-1:0] delay_ticks,
    input  logic [TICK_W-1:0] dur_ticks,
    output logic              drop_fire,
    output logic              restore_fire,
    output logic              fault_mark,
    output logic              param_err
);
    sched_state_t      state_q, state_d;
    logic [CNT_W-1:0]  target_q;
    logic [TICK_W-1:0] delay_q;
    logic [TICK_W-1:0] drop_at_q;
    logic [CNT_W-1:0]  pulses;
    logic [TICK_W-1:0] ticks;
    logic              cs_fall;
    logic              arm_ok;
    logic              tick_start;
    logic              fault_q;

    cs_fall_detect #(.STAGES(SYNC_DEPTH)) u_cs (
        .clk(clk), .rst_n(rst_n), .cs_n_async(cs_n), .fall(cs_fall)
    );

    sched_counter #(.W(CNT_W)) u_pulses (
        .clk(clk), .rst_n(rst_n), .clear(arm_ok),
        .inc(state_q == ST_COUNT && cs_fall), .count(pulses)
    );

    sched_counter #(.W(TICK_W)) u_ticks (
        .clk(clk), .rst_n(rst_n), .clear(tick_start),
        .inc(state_q == ST_WAIT), .count(ticks)
    );

    assign arm_ok = arm && (state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_ERR);
    assign tick_start = (state_d == ST_WAIT) && (state_q != ST_WAIT);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (arm) begin
                    if (dur_ticks > delay_ticks)   state_d = ST_ERR;
                    else if (pulse_target == '0)   state_d = ST_WAIT;
                    else                           state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (cs_fall && pulses == target_q - 1'b1) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (ticks == delay_q) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            target_q  <= '0;
            delay_q   <= '0;
            drop_at_q <= '0;
            fault_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= restore_fire;
            if (arm_ok) begin
                target_q  <= pulse_target;
                delay_q   <= delay_ticks;
                drop_at_q <= delay_ticks - dur_ticks;
            end
        end
    end

    // outputs
    always_comb begin
        drop_fire    = 1'b0;
        restore_fire = 1'b0;
        param_err    = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                drop_fire    = (ticks == drop_at_q);
                restore_fire = (ticks == delay_q);
            end
            ST_ERR:  param_err = 1'b1;
            default: ;
        endcase
    end
    assign fault_mark = fault_q;

    // assertion support
    logic drop_seen_q;
    logic fired_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drop_seen_q <= 1'b0;
            fired_q     <= 1'b0;
        end else if (arm_ok) begin
            drop_seen_q <= 1'b0;
            fired_q     <= 1'b0;
        end else begin
            if (drop_fire)    drop_seen_q <= 1'b1;
            if (restore_fire) fired_q     <= 1'b1;
        end
    end

    AST_MARK_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_fire |=> fault_mark);  // R5
    AST_DROP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        restore_fire |-> (drop_fire || drop_seen_q));  // R4
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        fired_q |-> !drop_fire && !restore_fire);  // R9
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        param_err |-> !drop_fire && !restore_fire);  // R7
    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (ticks <= delay_q));  // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (pulses < target_q));  // R2
endmodule

// File: tb/glitch_sched_test.sv
module glitch_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        arm = 1'b0;
    logic [7:0]  pulse_target = '0;
    logic [15:0] delay_ticks = '0;
    logic [15:0] dur_ticks = '0;
    logic        drop_fire, restore_fire, fault_mark, param_err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int n_drop = 0, n_rest = 0, n_mark = 0;
    int drop_cyc = -1, rest_cyc = -1, mark_cyc = -1;
    int b_drop, b_rest, b_mark;
    int arm_cyc, last_fall;

    glitch_sched uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .arm(arm),
        .pulse_target(pulse_target), .delay_ticks(delay_ticks), .dur_ticks(dur_ticks),
        .drop_fire(drop_fire), .restore_fire(restore_fire),
        .fault_mark(fault_mark), .param_err(param_err)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always begin
        @(posedge clk);
        #1;
        if (drop_fire)    begin n_drop++; drop_cyc = cyc; end
        if (restore_fire) begin n_rest++; rest_cyc = cyc; end
        if (fault_mark)   begin n_mark++; mark_cyc = cyc; end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic do_arm(input int tgt, input int dly, input int dur);
        pulse_target = tgt[7:0];
        delay_ticks  = dly[15:0];
        dur_ticks    = dur[15:0];
        arm = 1'b1;
        arm_cyc = cyc + 1;
        b_drop = n_drop; b_rest = n_rest; b_mark = n_mark;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic pulse(input int low, input int gap);
        cs_n = 1'b0;
        last_fall = cyc;
        repeat (low) @(negedge clk);
        cs_n = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic expect_fire(input int base, input int dly, input int dur, input string tag);
        chk(n_rest - b_rest == 1, {tag, " R3 restore count"}, n_rest - b_rest, 1);
        chk(rest_cyc == base + dly, {tag, " R3 restore cycle"}, rest_cyc, base + dly);
        chk(n_drop - b_drop == 1, {tag, " R4 drop count"}, n_drop - b_drop, 1);
        chk(drop_cyc == base + dly - dur, {tag, " R4 drop cycle"}, drop_cyc, base + dly - dur);
        chk(n_mark - b_mark == 1, {tag, " R5 mark count"}, n_mark - b_mark, 1);
        chk(mark_cyc == base + dly + 1, {tag, " R5 mark cycle"}, mark_cyc, base + dly + 1);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1207);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, bus activity without arm does nothing
        chk(!drop_fire && !restore_fire && !fault_mark && !param_err, "R1 reset outputs", 0, 0);
        pulse(2, 2); pulse(1, 3);
        repeat (10) @(negedge clk);
        chk(n_drop + n_rest + n_mark == 0, "R1 no fire unarmed", n_drop + n_rest + n_mark, 0);

        // R2: held-low level counts once
        do_arm(2, 5, 2);
        pulse(8, 2);
        pulse(1, 1);
        repeat (12) @(negedge clk);
        expect_fire(last_fall + 3, 5, 2, "R2 held low");

        // R4: zero duration coincides; zero delay
        do_arm(1, 4, 0);
        pulse(1, 1);
        repeat (10) @(negedge clk);
        expect_fire(last_fall + 3, 4, 0, "R4 zero dur");
        do_arm(1, 0, 0);
        pulse(2, 1);
        repeat (8) @(negedge clk);
        expect_fire(last_fall + 3, 0, 0, "R3 zero delay");

        // R6: zero target
        do_arm(0, 6, 2);
        repeat (12) @(negedge clk);
        expect_fire(arm_cyc, 6, 2, "R6 zero target");

        // R7: parameter error
        do_arm(2, 3, 5);
        chk(param_err == 1'b1, "R7 param_err set", param_err, 1);
        pulse(1, 1); pulse(1, 1);
        repeat (10) @(negedge clk);
        chk(n_drop - b_drop + n_rest - b_rest == 0, "R7 no fire on err", n_drop - b_drop + n_rest - b_rest, 0);
        do_arm(1, 3, 1);
        chk(param_err == 1'b0, "R7 param_err cleared", param_err, 0);
        pulse(1, 1);
        repeat (8) @(negedge clk);
        expect_fire(last_fall + 3, 3, 1, "R7 recover");

        // R8: arm while counting is ignored
        do_arm(3, 10, 4);
        pulse(1, 2);
        pulse_target = 8'd1; delay_ticks = 16'd2; dur_ticks = 16'd1; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        pulse(1, 2);
        pulse(2, 1);
        repeat (16) @(negedge clk);
        expect_fire(last_fall + 3, 10, 4, "R8 rearm ignored");

        // R9: falls during ticking ignored, then one shot
        do_arm(1, 30, 10);
        pulse(1, 2);
        begin
            int first;
            first = last_fall;
            pulse(1, 3); pulse(2, 3);
            repeat (35) @(negedge clk);
            expect_fire(first + 3, 30, 10, "R9 wait pulses");
        end
        b_drop = n_drop; b_rest = n_rest;
        pulse(1, 2); pulse(1, 2);
        repeat (12) @(negedge clk);
        chk(n_drop - b_drop + n_rest - b_rest == 0, "R9 one shot", n_drop - b_drop + n_rest - b_rest, 0);

        // random attempts
        for (int t = 0; t < 25; t++) begin
            int tgt, dly, dur;
            tgt = 1 + int'($urandom_range(0, 4));
            dly = int'($urandom_range(0, 24));
            dur = int'($urandom_range(0, dly));
            do_arm(tgt, dly, dur);
            for (int p = 0; p < tgt; p++)
                pulse(1 + int'($urandom_range(0, 3)), 1 + int'($urandom_range(0, 3)));
            repeat (dly + 8) @(negedge clk);
            expect_fire(last_fall + 3, dly, dur, "R3 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule